// File: doc/BRIEF.md
# Thermal Input Duty-Time Monitor

This block watches an active-low thermal throttle line and measures how much of a repeating time window the line spends asserted. Window length is picked by a 3-bit code and counted in ticks of an external timebase. The limit is an 8-bit fraction of 256. When a window closes with more asserted time than that fraction allows, a sticky over-limit flag is raised in a status byte. An active-low alert follows the flag unless it is masked. Two limit codes are special: zero flags on the very first assertion, and full scale never flags.

The same line can also be used as an output. The block pulls it low while an enabled local or remote over-temperature flag is active. The raw input passes through a two-flop synchronizer. Cycles in which the block is driving the line itself are left out of the measurement, so its own drive is never counted. On-time is sampled once per timebase tick. The window counter and the on-time counter restart together at each window boundary.

Top module: `thermDutyMon`

## Requirements
- R1: The window length is TICKS_PER_QTR × 2^k timebase ticks, where k is the window code for codes 0 to 4. Codes 5, 6 and 7 all give k = 5. After reset the first window starts at the first tick.
- R2: For a limit L other than 0x00 and 0xFF, the over-limit flag is set at the tick that closes a window when onTicks × 256 > L × windowTicks. onTicks is the number of ticks in that window at which the synchronized line was low. Equality does not set the flag, and the flag is never set in the middle of a window.
- R3: With L = 0x00, the flag is set within three clock cycles of the line going low, without waiting for the window to end.
- R4: With L = 0xFF, the flag is never set, even when the line stays low for a whole window.
- R5: Once set, the flag stays set until a one-cycle statusClr strobe clears it. If a set and a clear come in the same cycle, the set wins.
- R6: The status output carries the flag in bit 4. All other status bits read 0.
- R7: alertN is low exactly when the flag is set and alertMask is 0.
- R8: thermDriveN goes low one cycle after (localOver and thermEvtEn[0]) or (remoteOver and thermEvtEn[1]) becomes true. It returns high one cycle after neither is true.
- R9: Ticks at which the block is driving the line do not count as asserted time.
- R10: After reset the status byte is 0x00, alertN is 1 and thermDriveN is 1.
- R11: The on-time count restarts at each window boundary, so asserted time does not carry over from one window to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase pulse |
| thermInN | input | 1 | Raw active-low thermal line (unsynchronized) |
| windowSel | input | 3 | Window length code |
| pctLimit | input | 8 | On-time limit in 1/256 of the window |
| alertMask | input | 1 | 1 keeps alertN high |
| statusClr | input | 1 | Clears the sticky flag |
| localOver | input | 1 | Local over-temperature flag |
| remoteOver | input | 1 | Remote over-temperature flag |
| thermEvtEn | input | 2 | Bit 0 enables local, bit 1 enables remote line drive |
| thermDriveN | output | 1 | Active-low drive onto the thermal line |
| statusReg | output | 8 | Status byte, flag in bit 4 |
| alertN | output | 1 | Active-low alert |

## Verification
Directed runs hold the line low for a full window under every window code with a half-scale limit. The flag must stay clear up to the last tick and rise on that tick, which separates each window length from its neighbours and shows that codes 5 to 7 collapse to the same length. A boundary run places on-time exactly at the threshold and then one tick above it, which tells a strict comparison apart from an inclusive one. Two consecutive windows each just under the threshold show whether the counter restarts. Random windows mix codes, limits (including 0x00 and 0xFF), mask settings and line patterns against a bench model of the product comparison. Further runs cover the clear strobe, line drive, and line activity while the block drives the line itself.

// File: rtl/thermDutyPkg.sv
package thermDutyPkg;

  typedef struct packed {
    logic tickNow;  // timebase tick seen this cycle
    logic winEnd;   // this tick closes the current window
  } ctrlStrobe_t;

  // Power-of-two multiplier of the quarter unit for a window code.
  function automatic logic [2:0] winShift(input logic [2:0] sel);
    return (sel > 3'd5) ? 3'd5 : sel;
  endfunction

endpackage

// File: rtl/thermDutyDatapath.sv
module thermDutyDatapath
  import thermDutyPkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic             thermInN,
  input  logic [WIN_W-1:0] winLen,
  input  logic [7:0]       pctLimit,
  input  logic             localOver,
  input  logic             remoteOver,
  input  logic [1:0]       thermEvtEn,
  output logic             thermActive,
  output logic             overLimit,
  output logic             driveActive
);

  localparam int PROD_W = WIN_W + 8;

  logic             syncA, syncB;
  logic             driveDlyA, driveDlyB;
  logic [WIN_W-1:0] onCnt;
  logic [WIN_W-1:0] onNext;
  logic [PROD_W-1:0] onScaled;
  logic [PROD_W-1:0] limScaled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= thermInN;
      syncB <= syncA;
    end
  end

  // Own drive, delayed to line up with the synchronizer stages.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveActive <= 1'b0;
      driveDlyA   <= 1'b0;
      driveDlyB   <= 1'b0;
    end else begin
      driveActive <= (localOver & thermEvtEn[0]) | (remoteOver & thermEvtEn[1]);
      driveDlyA   <= driveActive;
      driveDlyB   <= driveDlyA;
    end
  end

  assign thermActive = ~syncB & ~driveDlyB & ~driveDlyA & ~driveActive;

  assign onNext = onCnt + WIN_W'(strb.tickNow & thermActive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt <= '0;
    end else if (strb.winEnd) begin
      onCnt <= '0;
    end else begin
      onCnt <= onNext;
    end
  end

  assign onScaled  = {onNext, 8'd0};
  assign limScaled = PROD_W'(pctLimit) * PROD_W'(winLen);
  assign overLimit = onScaled > limScaled;

endmodule

// File: rtl/thermDutyControl.sv
module thermDutyControl
  import thermDutyPkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [WIN_W-1:0] winLen,
  input  logic [7:0]       pctLimit,
  input  logic             statusClr,
  input  logic             thermActive,
  input  logic             overLimit,
  output ctrlStrobe_t      strb,
  output logic             thermFlag
);

  logic [WIN_W-1:0] winCnt;
  logic [WIN_W-1:0] winCntNext;
  logic             lastTick;
  logic             limZero, limFull;
  logic             setFlag;

  assign winCntNext   = winCnt + WIN_W'(1);
  assign lastTick     = winCntNext >= winLen;
  assign strb.tickNow = tick;
  assign strb.winEnd  = tick & lastTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (tick) begin
      winCnt <= lastTick ? '0 : winCntNext;
    end
  end

  assign limZero = pctLimit == 8'h00;
  assign limFull = pctLimit == 8'hFF;
  assign setFlag = (limZero & thermActive) |
                   (~limZero & ~limFull & strb.winEnd & overLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermFlag <= 1'b0;
    end else if (setFlag) begin
      thermFlag <= 1'b1;
    end else if (statusClr) begin
      thermFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/thermDutyMon.sv
module thermDutyMon
  import thermDutyPkg::*;
#(
  parameter int TICKS_PER_QTR = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       thermInN,
  input  logic [2:0] windowSel,
  input  logic [7:0] pctLimit,
  input  logic       alertMask,
  input  logic       statusClr,
  input  logic       localOver,
  input  logic       remoteOver,
  input  logic [1:0] thermEvtEn,
  output logic       thermDriveN,
  output logic [7:0] statusReg,
  output logic       alertN
);

  localparam int WIN_MAX = TICKS_PER_QTR * 32;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam logic [WIN_W-1:0] QTR = WIN_W'(TICKS_PER_QTR);

  ctrlStrobe_t      strb;
  logic [WIN_W-1:0] winLen;
  logic             thermActive, overLimit, driveActive, thermFlag;

  assign winLen = QTR << winShift(windowSel);

  thermDutyControl #(.WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .winLen(winLen),
    .pctLimit(pctLimit), .statusClr(statusClr), .thermActive(thermActive),
    .overLimit(overLimit), .strb(strb), .thermFlag(thermFlag)
  );

  thermDutyDatapath #(.WIN_W(WIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .thermInN(thermInN),
    .winLen(winLen), .pctLimit(pctLimit), .localOver(localOver),
    .remoteOver(remoteOver), .thermEvtEn(thermEvtEn),
    .thermActive(thermActive), .overLimit(overLimit), .driveActive(driveActive)
  );

  assign thermDriveN = ~driveActive;
  assign statusReg   = {3'b000, thermFlag, 4'b0000};
  assign alertN      = ~(thermFlag & ~alertMask);

endmodule

// File: rtl/thermDutyMonChk.sv
module thermDutyMonChk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic [7:0] pctLimit,
  input logic       alertMask,
  input logic       statusClr,
  input logic       localOver,
  input logic       remoteOver,
  input logic [1:0] thermEvtEn,
  input logic       thermDriveN,
  input logic [7:0] statusReg,
  input logic       alertN
);

  a_r2_rise_at_tick_or_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[4]) |-> ($past(tick) || $past(pctLimit) == 8'h00));

  a_r4_full_never: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[4]) |-> $past(pctLimit) != 8'hFF);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[4] && !statusClr) |=> statusReg[4]);

  a_r7_mask_holds_alert: assert property (@(posedge clk) disable iff (!rstN)
    alertMask |-> alertN);

  a_r8_drive_follows: assert property (@(posedge clk) disable iff (!rstN)
    ((localOver && thermEvtEn[0]) || (remoteOver && thermEvtEn[1])) |=> !thermDriveN);

endmodule

bind thermDutyMon thermDutyMonChk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .pctLimit(pctLimit),
  .alertMask(alertMask), .statusClr(statusClr), .localOver(localOver),
  .remoteOver(remoteOver), .thermEvtEn(thermEvtEn), .thermDriveN(thermDriveN),
  .statusReg(statusReg), .alertN(alertN)
);

// File: tb/thermDutyMon_bench.sv
module thermDutyMon_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TPQ = 2;

  logic       clk = 0;
  logic       rstN = 0;
  logic       tick = 0;
  logic       thermInN = 1;
  logic [2:0] windowSel = 0;
  logic [7:0] pctLimit = 0;
  logic       alertMask = 0;
  logic       statusClr = 0;
  logic       localOver = 0;
  logic       remoteOver = 0;
  logic [1:0] thermEvtEn = 0;
  logic       thermDriveN;
  logic [7:0] statusReg;
  logic       alertN;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  thermDutyMon #(.TICKS_PER_QTR(TPQ)) u_thermDutyMon (
    .clk(clk), .rstN(rstN), .tick(tick), .thermInN(thermInN),
    .windowSel(windowSel), .pctLimit(pctLimit), .alertMask(alertMask),
    .statusClr(statusClr), .localOver(localOver), .remoteOver(remoteOver),
    .thermEvtEn(thermEvtEn), .thermDriveN(thermDriveN),
    .statusReg(statusReg), .alertN(alertN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int winLenOf(input int sel);
    return TPQ * (1 << ((sel > 5) ? 5 : sel));
  endfunction

  function automatic bit expFlag(input int cnt, input int lim, input int w);
    if (lim == 0) return cnt > 0;
    if (lim == 255) return 0;
    return cnt * 256 > lim * w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; tick = 0; thermInN = 1; statusClr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  // One tick period: line level held for 4 clocks, tick on the last.
  task automatic tickPeriod(input bit lvl);
    thermInN = lvl;
    repeat (3) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic checkFlag(input string req, input bit exp, input bit mask);
    check(req, statusReg, exp ? 8'h10 : 8'h00);
    check("R7", alertN, !(exp && !mask));
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));

    doReset();
    // R10 reset state
    check("R10 status", statusReg, 8'h00);
    check("R10 alert", alertN, 1);
    check("R10 drive", thermDriveN, 1);

    // R1: continuous assertion, half-scale limit, each code
    for (int sel = 0; sel < 8; sel++) begin
      int w;
      w = winLenOf(sel);
      windowSel = 3'(sel); pctLimit = 8'h80; alertMask = 0;
      doReset();
      for (int i = 0; i < w - 1; i++) tickPeriod(0);
      check("R1 before end", statusReg, 8'h00);
      tickPeriod(0);
      check("R1 at end", statusReg, 8'h10);
    end

    // R2 boundary: sel 3 -> 16 ticks, limit 0x40 -> threshold 4
    windowSel = 3'd3; pctLimit = 8'h40;
    doReset();
    for (int i = 0; i < 16; i++) tickPeriod(i < 4 ? 0 : 1);
    check("R2 equal", statusReg, 8'h00);
    doReset();
    for (int i = 0; i < 16; i++) tickPeriod(i < 5 ? 0 : 1);
    check("R2 above", statusReg, 8'h10);

    // R11: two windows of 3 ticks each, no carry over
    doReset();
    for (int i = 0; i < 32; i++) tickPeriod((i % 16) < 3 ? 0 : 1);
    check("R11 restart", statusReg, 8'h00);

    // R3: limit zero, immediate
    pctLimit = 8'h00;
    doReset();
    thermInN = 0;
    repeat (3) @(negedge clk);
    check("R3 immediate", statusReg, 8'h10);
    thermInN = 1;

    // R5: sticky then clear, and set wins over clear
    pctLimit = 8'h40;
    repeat (10) @(negedge clk);
    check("R5 sticky", statusReg, 8'h10);
    statusClr = 1; @(negedge clk); statusClr = 0;
    check("R5 cleared", statusReg, 8'h00);
    check("R6 bits", statusReg & 8'hEF, 0);
    pctLimit = 8'h00; thermInN = 0;
    repeat (3) @(negedge clk);
    statusClr = 1; @(negedge clk); @(negedge clk); statusClr = 0;
    check("R5 set wins", statusReg, 8'h10);
    thermInN = 1;

    // R4: full scale never flags
    windowSel = 3'd0; pctLimit = 8'hFF;
    doReset();
    for (int i = 0; i < 6; i++) tickPeriod(0);
    check("R4 full", statusReg, 8'h00);
    thermInN = 1;

    // R8: drive output
    doReset();
    localOver = 1; thermEvtEn = 2'b10;
    @(negedge clk);
    check("R8 local disabled", thermDriveN, 1);
    thermEvtEn = 2'b01; @(negedge clk);
    check("R8 local", thermDriveN, 0);
    localOver = 0; remoteOver = 1; thermEvtEn = 2'b10; @(negedge clk);
    check("R8 remote", thermDriveN, 0);
    remoteOver = 0; @(negedge clk);
    check("R8 release", thermDriveN, 1);

    // R9: own drive not counted (line echoes drive)
    windowSel = 3'd1; pctLimit = 8'h01;
    localOver = 1; thermEvtEn = 2'b01;
    doReset();
    for (int i = 0; i < 4; i++) tickPeriod(0);
    check("R9 excluded", statusReg, 8'h00);
    localOver = 0; thermInN = 1;
    repeat (4) @(negedge clk);

    // Random windows: R2 R4 R3 R7
    for (int t = 0; t < 30; t++) begin
      int sel, lim, w, cnt, pct;
      bit mask, lvl;
      sel = int'($urandom_range(0, 7));
      case ($urandom_range(0, 7))
        0: lim = 0;
        1: lim = 255;
        default: lim = int'($urandom_range(1, 254));
      endcase
      mask = 1'($urandom_range(0, 1));
      pct = int'($urandom_range(0, 100));
      w = winLenOf(sel);
      windowSel = 3'(sel); pctLimit = 8'(lim); alertMask = mask;
      doReset();
      cnt = 0;
      for (int i = 0; i < w; i++) begin
        lvl = ($urandom_range(0, 99) < pct) ? 1'b0 : 1'b1;
        if (!lvl) cnt++;
        tickPeriod(lvl);
      end
      thermInN = 1;
      checkFlag("R2 random", expFlag(cnt, lim, w), mask);
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule